// File: doc/BRIEF.md
# Constant-Divisor Quotient Pipeline

This block divides a stream of unsigned dividends by a divisor that is fixed in advance. It has no divide array. Each beat brings its own division recipe: a mode code, an N-bit multiplier and a final shift count, all computed offline for the chosen divisor. The datapath then produces floor(n/d) using a high-half multiply and shifts. One dividend may enter on every clock cycle, and the quotient leaves exactly three cycles later with its valid flag. There is no back-pressure.

Five recipes are supported. A power-of-two divisor needs only a shift. A cooperative divisor takes the high half of magic × n. An even divisor whose multiplier would need N+1 bits halves the dividend before the multiply. The classic N+1-bit recipe applies a subtract/halve/add correction to the high half. The round-down recipe multiplies by n+1 with a multiplier rounded down, which removes that correction. Round-down has to stay exact at the all-ones dividend. One elaboration parameter picks how it does so: either the increment saturates, or the product is built as magic × n + magic across the full double width.

The recipe travels with its dividend through every stage. Beats for different divisors can therefore be interleaved without draining the pipe.

Top module: `cdiv_top`

## Requirements
- R1: While reset is high, and on the cycle after it falls, out_valid is 0. Beats offered during reset produce no output.
- R2: A beat accepted with in_valid=1 at a clock edge appears with out_valid=1 exactly three edges later. Idle cycles in the input stream reappear as idle cycles at the output, and one result is produced per cycle.
- R3: Mode code 0 (power of two): the quotient is the dividend shifted right by in_shift, and in_magic is ignored.
- R4: Mode code 1 (direct multiply): the quotient is the upper N bits of in_magic × n, shifted right by in_shift.
- R5: Mode code 2 (halve first): the quotient is the upper N bits of in_magic × (n >> 1), shifted right by in_shift.
- R6: Mode code 3 (corrected multiply): with hi the upper N bits of in_magic × n, the quotient is (((n − hi) >> 1) + hi) >> in_shift.
- R7: Mode code 4 (round-down): the quotient is the upper N bits of in_magic × (n + 1), shifted right by in_shift.
- R8: With OVF_STYLE = 0 (saturating), an all-ones dividend in mode 4 is not incremented. The quotient is still floor(n/d) for a divisor that needs the round-down recipe.
- R9: With OVF_STYLE = 1 (distributed), mode 4 forms in_magic × n + in_magic over 2N bits, and the carry out of the low half reaches the upper half. The all-ones dividend gives floor(n/d).
- R10: Mode, multiplier and shift are captured per beat. Consecutive beats with different recipes each give their own correct quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Dividend beat present |
| in_dividend | input | DATA_W | Unsigned dividend n |
| in_mode | input | 3 | Recipe code, 0 to 4 as in R3 to R7 |
| in_magic | input | DATA_W | Precomputed multiplier |
| in_shift | input | $clog2(DATA_W) | Final right-shift count |
| out_valid | output | 1 | Quotient present |
| out_quotient | output | DATA_W | floor(n/d) |

## Verification
Every recipe is fed the dividends 0, 1, d−1, d, 2^N−2 and 2^N−1, plus random values, and each result is compared with a true division.

The all-ones dividend in round-down mode is the key case. A wrapping increment returns 0 there, and a distributed sum that drops the low-half carry comes out one short. The dividends d−1 and d expose an off-by-one multiplier or a missing correction step. 2^N−2 catches a saturation compare that fires one value too early.

Recipes change on consecutive beats and the input has bubbles. A stage that latches its recipe late, or that loses or duplicates a valid flag, therefore gives a wrong quotient or a result in the wrong cycle.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Recipe codes; the stages decode these values.
    typedef enum logic [2:0] {
        DM_POW2  = 3'd0,
        DM_PLAIN = 3'd1,
        DM_HALVE = 3'd2,
        DM_FIXUP = 3'd3,
        DM_FLOOR = 3'd4
    } div_mode_e;

    // How round-down avoids the wrap of n+1 at the all-ones dividend.
    localparam int OVF_SATURATE   = 0;
    localparam int OVF_DISTRIBUTE = 1;

endpackage

// File: rtl/cdiv_pre.sv
module cdiv_pre
    import cdiv_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SH_W      = 5,
    parameter int OVF_STYLE = OVF_SATURATE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_dividend,
    input  div_mode_e         in_mode,
    input  logic [DATA_W-1:0] in_magic,
    input  logic [SH_W-1:0]   in_shift,
    output logic              s1_valid,
    output div_mode_e         s1_mode,
    output logic [DATA_W-1:0] s1_magic,
    output logic [SH_W-1:0]   s1_shift,
    output logic [DATA_W-1:0] s1_operand,
    output logic              s1_add_magic
);

    logic [DATA_W-1:0] floor_op;
    logic              floor_add;
    logic [DATA_W-1:0] op_c;
    logic              add_c;

    // Round-down operand: either a saturating increment or a later +magic.
    generate
        if (OVF_STYLE == OVF_SATURATE) begin : g_sat
            assign floor_op  = (&in_dividend) ? in_dividend : in_dividend + DATA_W'(1);
            assign floor_add = 1'b0;
        end else begin : g_dist
            assign floor_op  = in_dividend;
            assign floor_add = 1'b1;
        end
    endgenerate

    always_comb begin
        op_c  = in_dividend;
        add_c = 1'b0;
        case (in_mode)
            DM_HALVE: op_c = in_dividend >> 1;
            DM_FLOOR: begin
                op_c  = floor_op;
                add_c = floor_add;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid     <= 1'b0;
            s1_mode      <= DM_POW2;
            s1_magic     <= '0;
            s1_shift     <= '0;
            s1_operand   <= '0;
            s1_add_magic <= 1'b0;
        end else begin
            s1_valid     <= in_valid;
            s1_mode      <= in_mode;
            s1_magic     <= in_magic;
            s1_shift     <= in_shift;
            s1_operand   <= op_c;
            s1_add_magic <= add_c;
        end
    end

endmodule

// File: rtl/cdiv_mul.sv
module cdiv_mul
    import cdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  div_mode_e         s1_mode,
    input  logic [DATA_W-1:0] s1_magic,
    input  logic [SH_W-1:0]   s1_shift,
    input  logic [DATA_W-1:0] s1_operand,
    input  logic              s1_add_magic,
    output logic              s2_valid,
    output div_mode_e         s2_mode,
    output logic [SH_W-1:0]   s2_shift,
    output logic [DATA_W-1:0] s2_operand,
    output logic [DATA_W-1:0] s2_hi
);

    localparam int PW = 2 * DATA_W;

    logic [PW-1:0] full_c;
    logic          unused_lo;

    // Double-width product; the optional +magic term carries into the top half.
    assign full_c    = PW'(s1_magic) * PW'(s1_operand)
                     + (s1_add_magic ? PW'(s1_magic) : PW'(0));
    assign unused_lo = ^full_c[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid   <= 1'b0;
            s2_mode    <= DM_POW2;
            s2_shift   <= '0;
            s2_operand <= '0;
            s2_hi      <= '0;
        end else begin
            s2_valid   <= s1_valid;
            s2_mode    <= s1_mode;
            s2_shift   <= s1_shift;
            s2_operand <= s1_operand;
            s2_hi      <= full_c[PW-1:DATA_W];
        end
    end

endmodule

// File: rtl/cdiv_post.sv
module cdiv_post
    import cdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s2_valid,
    input  div_mode_e         s2_mode,
    input  logic [SH_W-1:0]   s2_shift,
    input  logic [DATA_W-1:0] s2_operand,
    input  logic [DATA_W-1:0] s2_hi,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_quotient
);

    logic [DATA_W-1:0] diff_c;
    logic [DATA_W-1:0] mid_c;
    logic [DATA_W-1:0] res_c;

    // Correction for the N+1-bit multiplier: hi <= n, so no wrap occurs.
    assign diff_c = s2_operand - s2_hi;
    assign mid_c  = (diff_c >> 1) + s2_hi;

    always_comb begin
        case (s2_mode)
            DM_POW2:  res_c = s2_operand >> s2_shift;
            DM_FIXUP: res_c = mid_c >> s2_shift;
            default:  res_c = s2_hi >> s2_shift;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_quotient <= '0;
        end else begin
            out_valid    <= s2_valid;
            out_quotient <= res_c;
        end
    end

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int OVF_STYLE = OVF_SATURATE,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_dividend,
    input  logic [2:0]        in_mode,
    input  logic [DATA_W-1:0] in_magic,
    input  logic [SH_W-1:0]   in_shift,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_quotient
);

    logic              s1_valid;
    div_mode_e         s1_mode;
    logic [DATA_W-1:0] s1_magic;
    logic [SH_W-1:0]   s1_shift;
    logic [DATA_W-1:0] s1_operand;
    logic              s1_add_magic;

    logic              s2_valid;
    div_mode_e         s2_mode;
    logic [SH_W-1:0]   s2_shift;
    logic [DATA_W-1:0] s2_operand;
    logic [DATA_W-1:0] s2_hi;

    cdiv_pre #(
        .DATA_W(DATA_W), .SH_W(SH_W), .OVF_STYLE(OVF_STYLE)
    ) pre_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_dividend(in_dividend),
        .in_mode(div_mode_e'(in_mode)), .in_magic(in_magic), .in_shift(in_shift),
        .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_magic(s1_magic),
        .s1_shift(s1_shift), .s1_operand(s1_operand), .s1_add_magic(s1_add_magic)
    );

    cdiv_mul #(.DATA_W(DATA_W), .SH_W(SH_W)) mul_i (
        .clk(clk), .rst(rst),
        .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_magic(s1_magic),
        .s1_shift(s1_shift), .s1_operand(s1_operand), .s1_add_magic(s1_add_magic),
        .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_shift(s2_shift),
        .s2_operand(s2_operand), .s2_hi(s2_hi)
    );

    cdiv_post #(.DATA_W(DATA_W), .SH_W(SH_W)) post_i (
        .clk(clk), .rst(rst),
        .s2_valid(s2_valid), .s2_mode(s2_mode), .s2_shift(s2_shift),
        .s2_operand(s2_operand), .s2_hi(s2_hi),
        .out_valid(out_valid), .out_quotient(out_quotient)
    );

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
    import cdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_dividend,
    input logic [2:0]        in_mode,
    input logic [DATA_W-1:0] in_magic,
    input logic [SH_W-1:0]   in_shift,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_quotient
);

    logic [1:0] warm = 2'd0;
    logic       rst_q = 1'b0;
    logic       unused_magic;

    assign unused_magic = ^in_magic;

    // Edges since reset fell, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    always @(negedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R1: assert (!out_valid);
        end
    end

    assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_pow2_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(in_mode, 3) == 3'd0)
        |-> (out_quotient == ($past(in_dividend, 3) >> $past(in_shift, 3))));

    assert_plain_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(in_mode, 3) == 3'd1)
        |-> (out_quotient <= ($past(in_dividend, 3) >> $past(in_shift, 3))));

    assert_floor_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && $past(in_mode, 3) == 3'd4)
        |-> (out_quotient <= ($past(in_dividend, 3) >> $past(in_shift, 3))));

endmodule

bind cdiv_top cdiv_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cdiv_top_tb_top.sv
`timescale 1ns/1ps
module cdiv_top_tb_top;

    typedef struct packed {
        logic [31:0] d;
        logic [2:0]  mode;
        logic [31:0] magic;
        logic [4:0]  sh;
    } cfg_t;

    typedef struct {
        logic [31:0] expq;
        logic [31:0] n;
        string       tag;
        int unsigned issue;
    } pend_t;

    localparam int NUM_CFG = 7;
    localparam cfg_t TABLE [NUM_CFG] = '{
        '{32'd16, 3'd0, 32'd0,          5'd4},  // R3
        '{32'd1,  3'd0, 32'd12345,      5'd0},  // R3, magic ignored
        '{32'd3,  3'd1, 32'd2863311531, 5'd1},  // R4
        '{32'd10, 3'd1, 32'd3435973837, 5'd3},  // R4
        '{32'd14, 3'd2, 32'd2454267027, 5'd2},  // R5
        '{32'd7,  3'd3, 32'd613566757,  5'd2},  // R6
        '{32'd7,  3'd4, 32'd1227133513, 5'd1}   // R7, R8, R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_dividend = '0;
    logic [2:0]  in_mode = '0;
    logic [31:0] in_magic = '0;
    logic [4:0]  in_shift = '0;
    logic        out_valid, out_valid_d;
    logic [31:0] out_quotient, out_quotient_d;

    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;
    pend_t       pend [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cdiv_top #(.DATA_W(32), .OVF_STYLE(0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dividend(in_dividend),
        .in_mode(in_mode), .in_magic(in_magic), .in_shift(in_shift),
        .out_valid(out_valid), .out_quotient(out_quotient)
    );

    cdiv_top #(.DATA_W(32), .OVF_STYLE(1)) dut_dist_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dividend(in_dividend),
        .in_mode(in_mode), .in_magic(in_magic), .in_shift(in_shift),
        .out_valid(out_valid_d), .out_quotient(out_quotient_d)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic send(input cfg_t c, input logic [31:0] n, input string tag);
        pend_t p;
        @(negedge clk);
        in_valid    = 1'b1;
        in_dividend = n;
        in_mode     = c.mode;
        in_magic    = c.magic;
        in_shift    = c.sh;
        p.expq  = n / c.d;
        p.n     = n;
        p.tag   = tag;
        p.issue = cyc;
        pend.push_back(p);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Result monitor: order, timing (R2) and value for both overflow styles.
    always @(negedge clk) begin
        if (!rst) begin
            check(out_valid_d == out_valid, "R2 dist valid", 32'(out_valid_d), 32'(out_valid));
            if (out_valid) begin
                if (pend.size() == 0) begin
                    check(1'b0, "R2 spurious out_valid", 32'd1, 32'd0);
                end else begin
                    pend_t p;
                    string tag_d;
                    p = pend.pop_front();
                    tag_d = (p.tag == "R8") ? "R9" : p.tag;
                    check(cyc == p.issue + 3, "R2 latency", cyc - p.issue, 32'd3);
                    check(out_quotient == p.expq, p.tag, out_quotient, p.expq);
                    check(out_quotient_d == p.expq, tag_d, out_quotient_d, p.expq);
                end
            end
        end
    end

    initial begin
        logic [31:0] corner [6];
        logic [31:0] r;
        // R1: beats offered during reset leave no trace.
        in_valid    = 1'b1;
        in_dividend = 32'd77;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!out_valid && !out_valid_d, "R1 valid in reset", 32'(out_valid), 32'd0);
        end
        in_valid = 1'b0;
        rst      = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid && !out_valid_d, "R1 valid after reset", 32'(out_valid), 32'd0);
        end

        // Table walk, back to back; the recipe changes between beats (R10).
        for (int e = 0; e < NUM_CFG; e++) begin
            corner[0] = 32'd0;
            corner[1] = 32'd1;
            corner[2] = TABLE[e].d - 32'd1;
            corner[3] = TABLE[e].d;
            corner[4] = 32'hFFFF_FFFE;
            corner[5] = 32'hFFFF_FFFF;
            for (int k = 0; k < 6; k++) begin
                if (TABLE[e].mode == 3'd4 && k == 5) send(TABLE[e], corner[k], "R8");
                else send(TABLE[e], corner[k], mode_tag(TABLE[e].mode));
            end
            for (int k = 0; k < 6; k++) begin
                r = $urandom;
                send(TABLE[e], r, mode_tag(TABLE[e].mode));
            end
        end
        idle(2);

        // R10: alternating recipes every beat, with R2 bubbles between pairs.
        for (int k = 0; k < 6; k++) begin
            r = $urandom;
            send(TABLE[6], r, "R10");
            send(TABLE[0], r, "R10");
            send(TABLE[5], r, "R10");
            send(TABLE[4], r, "R10");
            idle(k % 3);
        end
        // R9/R8 again right after a round-up beat on the same divisor.
        send(TABLE[5], 32'hFFFF_FFFF, "R6");
        send(TABLE[6], 32'hFFFF_FFFF, "R8");
        send(TABLE[6], 32'hFFFF_FFFE, "R7");
        idle(8);
        check(pend.size() == 0, "R2 all results drained", pend.size(), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule